// File: doc/BRIEF.md
# SPI Master with Byte FIFOs

A memory-mapped SPI master that moves 8-bit words between a 16-entry transmit queue and a 16-entry receive queue. Software loads bytes through a data port, sets the run flag, and the shift engine sends each queued byte on the serial output, most significant bit first. The byte captured on the serial input during the same eight clock periods goes into the receive queue. The engine keeps working while the run flag is set and the transmit queue is not empty. The selected chip-select line stays at its asserted level for as long as the run flag is set, so several bursts can share one chip-select window.

The bus side is a single-cycle synchronous port. A write lands on the rising clock edge. Read data is combinational from the address, and a read of the data port pops the receive queue on the same edge. There are three registers. The control/status word is at byte offset 0x00, the data port at 0x04 and the clock divider at 0x08. Any other offset reads as zero and ignores writes.

The control word holds the chip-select choice in bits 1:0 (3 selects no line), the phase in bit 2, the polarity in bit 3, the self-clearing queue flush strobes in bits 4 (transmit) and 5 (receive), the shared active-high select in bit 6, the run flag in bit 7, the completion interrupt enable in bit 9, the receive interrupt enable in bit 10, and the per-line active-high selects in bits 23:21. Read-only status sits in bits 20:16. From low to high these are: complete, receive data present, transmit room, receive watermark reached, receive full. One level interrupt output combines the two enabled conditions.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset the control/status word reads 0x0004_0000 (only transmit room set), the divider reads 0, all chip-select lines sit high, and the serial clock, serial output and interrupt are low.
- R2: Every byte written to the data port is shifted out most significant bit first, and the byte sampled on the serial input is appended to the receive queue, so that reads return the received bytes in the order they were sent.
- R3: The serial clock rests at the level of control bit 3. With bit 2 clear the input is sampled on the first edge of each bit and the output changes on the second. With bit 2 set the output changes on the first edge and the input is sampled on the second. A loop from output to input returns every byte unchanged in all four settings.
- R4: The serial clock period in system clocks equals the divider value for the powers of two from 2 upward, and a divider of 0 gives a period of 65536 clocks.
- R5: Status bit 16 (complete) is set exactly when the run flag is set, the transmit queue is empty and no byte is shifting. This includes the cycle right after the run flag is written with an empty transmit queue.
- R6: Status bit 19 is set while the receive queue holds 12 or more bytes, and bit 20 is set while it holds 16.
- R7: The interrupt output is high exactly when (bit 16 and enable bit 9) or (bit 19 and enable bit 10) holds, and it falls when the condition clears.
- R8: While the run flag is set and bits 1:0 pick line i (0 to 2), line i drives its asserted level, which is high when bit 21+i or bit 6 is set and low otherwise. Every other line, and every line while the run flag is clear or bits 1:0 equal 3, drives the inverse of its own asserted level.
- R9: A data-port write while the transmit queue holds 16 bytes is dropped, and status bit 18 is clear while the queue is full.
- R10: A data-port read while the receive queue is empty returns 0 and leaves the queue unchanged.
- R11: While the receive queue is full the engine starts no new byte, so no received byte is lost. It resumes once a byte has been read.
- R12: Writing a 1 to control bit 4 or bit 5 empties the transmit or receive queue. Both bits read back as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe; pops the receive queue at the data port |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_line | output | 3 | Chip-select lines |
| irq | output | 1 | Level interrupt |

## Verification
The serial output is looped back to the serial input, and a different byte pattern is sent in each of the four clock polarity and phase settings. A phase error shows up as shifted or corrupted bytes, and a polarity error shows up as the wrong resting level. Because the loopback would hide a reversed bit order, the bits on the output are also captured on the sampling edge and compared with the sent byte. Divider values 2, 8 and 0 are timed edge to edge, which separates a linear divider, a halved divider and a missing zero case. Queue sequences of 11, 12, 16 and 17 bytes reach both sides of the watermark, the full stall, the dropped write and the empty read. Each chip-select line is then driven with its own polarity and with the shared polarity.

// File: rtl/spim_pkg.sv
package spim_pkg;

    localparam int BUS_W     = 32;
    localparam int ADDR_W    = 5;
    localparam int DIV_W     = 16;
    localparam int CS_LINES  = 3;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_DATA = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_DIV  = 5'h08;

    localparam int B_CPHA    = 2;
    localparam int B_CPOL    = 3;
    localparam int B_FLUSH_T = 4;
    localparam int B_FLUSH_R = 5;
    localparam int B_POL_ALL = 6;
    localparam int B_RUN     = 7;
    localparam int B_IE_DONE = 9;
    localparam int B_IE_RX   = 10;
    localparam int B_STAT    = 16;
    localparam int B_LINEPOL = 21;

    typedef struct packed {
        logic [CS_LINES-1:0] line_pol;
        logic                ie_rx;
        logic                ie_done;
        logic                run;
        logic                pol_all;
        logic                cpol;
        logic                cpha;
        logic [1:0]          cs_pick;
    } ctrl_t;

    typedef struct packed {
        logic rx_full;
        logic rx_mark;
        logic tx_room;
        logic rx_avail;
        logic done;
    } stat_t;

    function automatic ctrl_t ctrl_from_word(input logic [BUS_W-1:0] w);
        ctrl_t c;
        c.line_pol = w[B_LINEPOL +: CS_LINES];
        c.ie_rx    = w[B_IE_RX];
        c.ie_done  = w[B_IE_DONE];
        c.run      = w[B_RUN];
        c.pol_all  = w[B_POL_ALL];
        c.cpol     = w[B_CPOL];
        c.cpha     = w[B_CPHA];
        c.cs_pick  = w[1:0];
        return c;
    endfunction

    function automatic logic [BUS_W-1:0] word_from_ctrl(input ctrl_t c, input stat_t s);
        logic [BUS_W-1:0] w;
        w = '0;
        w[B_LINEPOL +: CS_LINES] = c.line_pol;
        w[B_STAT +: 5]           = s;
        w[B_IE_RX]               = c.ie_rx;
        w[B_IE_DONE]             = c.ie_done;
        w[B_RUN]                 = c.run;
        w[B_POL_ALL]             = c.pol_all;
        w[B_CPOL]                = c.cpol;
        w[B_CPHA]                = c.cpha;
        w[1:0]                   = c.cs_pick;
        return w;
    endfunction

    // Half of the serial clock period, in system clocks.
    function automatic logic [DIV_W-1:0] half_period(input logic [DIV_W-1:0] d);
        if (d == '0)
            return {1'b1, {(DIV_W-1){1'b0}}};
        else if (d[DIV_W-1:1] == '0)
            return DIV_W'(1);
        else
            return {1'b0, d[DIV_W-1:1]};
    endfunction

endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign head    = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !(rst || flush))
            mem[wr_ptr] <= push_data;
    end

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop && !flush) |=> (count == $past(count)));

    assert_empty_read_R10: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push && !flush) |=> empty);

endmodule

// File: rtl/spim_shifter.sv
module spim_shifter
    import spim_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int EDGES  = 2 * DATA_W,
    localparam int EDGE_W = $clog2(EDGES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              may_start,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              cpol,
    input  logic              cpha,
    input  logic [DIV_W-1:0]  divider,
    input  logic              miso,
    output logic              take,
    output logic              busy,
    output logic              rx_push,
    output logic [DATA_W-1:0] rx_byte,
    output logic              sclk,
    output logic              mosi
);

    logic              busy_q, phase_q, mosi_q;
    logic [DIV_W-1:0]  tick_q, half;
    logic [EDGE_W-1:0] edge_q;
    logic [DATA_W-1:0] txsh_q, rxsh_q;
    logic              edge_now, leading, last_edge;

    assign half      = half_period(divider);
    assign take      = may_start && !busy_q;
    assign edge_now  = busy_q && (tick_q == half - 1'b1);
    assign leading   = ~edge_q[0];
    assign last_edge = (edge_q == EDGE_W'(EDGES - 1));

    assign busy    = busy_q;
    assign sclk    = cpol ^ phase_q;
    assign mosi    = mosi_q;
    assign rx_push = edge_now && last_edge;
    assign rx_byte = cpha ? {rxsh_q[DATA_W-2:0], miso} : rxsh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            phase_q <= 1'b0;
            mosi_q  <= 1'b0;
            tick_q  <= '0;
            edge_q  <= '0;
            txsh_q  <= '0;
            rxsh_q  <= '0;
        end else if (take) begin
            busy_q  <= 1'b1;
            phase_q <= 1'b0;
            tick_q  <= '0;
            edge_q  <= '0;
            mosi_q  <= tx_byte[DATA_W-1];
            txsh_q  <= cpha ? tx_byte : (tx_byte << 1);
        end else if (edge_now) begin
            tick_q  <= '0;
            phase_q <= ~phase_q;
            edge_q  <= edge_q + 1'b1;
            if (leading == cpha) begin
                mosi_q <= txsh_q[DATA_W-1];
                txsh_q <= txsh_q << 1;
            end else begin
                rxsh_q <= {rxsh_q[DATA_W-2:0], miso};
            end
            if (last_edge)
                busy_q <= 1'b0;
        end else if (busy_q) begin
            tick_q <= tick_q + 1'b1;
        end
    end

    assert_idle_level_R3: assert property (@(posedge clk) disable iff (rst)
        !busy_q |-> (sclk == cpol));

endmodule

// File: rtl/spim_csgen.sv
module spim_csgen
    import spim_pkg::*;
(
    input  logic                run,
    input  logic [1:0]          pick,
    input  logic                pol_all,
    input  logic [CS_LINES-1:0] line_pol,
    output logic [CS_LINES-1:0] lines
);

    for (genvar i = 0; i < CS_LINES; i++) begin : g_line
        logic level_on, chosen;
        assign level_on = line_pol[i] | pol_all;
        assign chosen   = run && (pick == 2'(i));
        assign lines[i] = chosen ? level_on : ~level_on;
    end

endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
    import spim_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int Q_DEPTH = 16,
    parameter int RX_MARK = 12,
    localparam int CNT_W  = $clog2(Q_DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_we,
    input  logic                bus_re,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [BUS_W-1:0]    bus_wdata,
    output logic [BUS_W-1:0]    bus_rdata,
    output logic                sclk,
    output logic                mosi,
    input  logic                miso,
    output logic [CS_LINES-1:0] cs_line,
    output logic                irq
);

    ctrl_t             ctrl_q;
    stat_t             stat;
    logic [DIV_W-1:0]  div_q;

    logic              wr_ctrl, wr_data, wr_div, rd_data;
    logic              flush_tx, flush_rx;
    logic [DATA_W-1:0] tx_head, rx_head, rx_byte;
    logic [CNT_W-1:0]  tx_cnt, rx_cnt;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic              eng_take, eng_busy, rx_push;

    assign wr_ctrl  = bus_we && (bus_addr == OFS_CTRL);
    assign wr_data  = bus_we && (bus_addr == OFS_DATA);
    assign wr_div   = bus_we && (bus_addr == OFS_DIV);
    assign rd_data  = bus_re && (bus_addr == OFS_DATA);
    assign flush_tx = wr_ctrl && bus_wdata[B_FLUSH_T];
    assign flush_rx = wr_ctrl && bus_wdata[B_FLUSH_R];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            div_q  <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= ctrl_from_word(bus_wdata);
            if (wr_div)  div_q  <= bus_wdata[DIV_W-1:0];
        end
    end

    spim_fifo #(.WIDTH(DATA_W), .DEPTH(Q_DEPTH)) u_txq (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush_tx),
        .push      (wr_data),
        .push_data (bus_wdata[DATA_W-1:0]),
        .pop       (eng_take),
        .head      (tx_head),
        .count     (tx_cnt),
        .full      (tx_full),
        .empty     (tx_empty)
    );

    spim_fifo #(.WIDTH(DATA_W), .DEPTH(Q_DEPTH)) u_rxq (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush_rx),
        .push      (rx_push),
        .push_data (rx_byte),
        .pop       (rd_data),
        .head      (rx_head),
        .count     (rx_cnt),
        .full      (rx_full),
        .empty     (rx_empty)
    );

    spim_shifter #(.DATA_W(DATA_W)) u_eng (
        .clk       (clk),
        .rst       (rst),
        .may_start (ctrl_q.run && !tx_empty && !rx_full),
        .tx_byte   (tx_head),
        .cpol      (ctrl_q.cpol),
        .cpha      (ctrl_q.cpha),
        .divider   (div_q),
        .miso      (miso),
        .take      (eng_take),
        .busy      (eng_busy),
        .rx_push   (rx_push),
        .rx_byte   (rx_byte),
        .sclk      (sclk),
        .mosi      (mosi)
    );

    spim_csgen u_cs (
        .run      (ctrl_q.run),
        .pick     (ctrl_q.cs_pick),
        .pol_all  (ctrl_q.pol_all),
        .line_pol (ctrl_q.line_pol),
        .lines    (cs_line)
    );

    assign stat.done     = ctrl_q.run && tx_empty && !eng_busy;
    assign stat.rx_avail = !rx_empty;
    assign stat.tx_room  = !tx_full;
    assign stat.rx_mark  = (rx_cnt >= CNT_W'(RX_MARK));
    assign stat.rx_full  = rx_full;

    assign irq = (stat.done && ctrl_q.ie_done) || (stat.rx_mark && ctrl_q.ie_rx);

    always_comb begin
        case (bus_addr)
            OFS_CTRL: bus_rdata = word_from_ctrl(ctrl_q, stat);
            OFS_DATA: bus_rdata = rx_empty ? '0 : BUS_W'(rx_head);
            OFS_DIV:  bus_rdata = BUS_W'(div_q);
            default:  bus_rdata = '0;
        endcase
    end

    assert_no_lost_rx_R11: assert property (@(posedge clk) disable iff (rst)
        rx_push |-> !rx_full);

    assert_start_gated_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(eng_busy) |-> !$past(rx_full));

    assert_irq_source_R7: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ctrl_q.run || rx_cnt >= CNT_W'(RX_MARK)));

endmodule

// File: tb/spi_fifo_master_bench.sv
`timescale 1ns/1ps
module spi_fifo_master_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0, bus_re = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sclk, mosi, miso;
    logic [2:0]  cs_line;
    logic        irq;

    int n_checks = 0;
    int n_fails  = 0;

    localparam logic [4:0] A_CTRL = 5'h00, A_DATA = 5'h04, A_DIV = 5'h08;
    localparam logic [31:0] K_CPHA = 32'h4, K_CPOL = 32'h8, K_FLT = 32'h10,
        K_FLR = 32'h20, K_POLALL = 32'h40, K_RUN = 32'h80,
        K_IED = 32'h200, K_IER = 32'h400;

    always #2 clk = ~clk;
    assign miso = mosi;

    spi_fifo_master u_spi_fifo_master (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_line(cs_line), .irq(irq)
    );

    logic       cap_en = 1'b0;
    logic [7:0] cap = '0;
    always @(posedge sclk) if (cap_en) cap <= {cap[6:0], mosi};

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_re = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        logic [31:0] s;
        s = '0;
        for (int i = 0; i < 4000; i++) begin
            rd(A_CTRL, s);
            if (s[16]) break;
        end
        chk(tag, 32'(s[16]), 32'd1);
    endtask

    function automatic logic [7:0] pat(input int a, input int b);
        return 8'(a * 37 + b * 91 + 5);
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        n_fails++;
        $display("FAIL R5 watchdog actual=hang expected=completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        int half;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // Reset state
        rd(A_CTRL, v); chk("R1 ctrl after reset", v, 32'h0004_0000);
        rd(A_DIV, v);  chk("R1 divider after reset", v, 32'h0);
        chk("R1 cs lines idle", 32'(cs_line), 32'h7);
        chk("R1 sclk/mosi/irq low", {29'b0, sclk, mosi, irq}, 32'h0);

        // Completion on enable with empty queue
        wr(A_CTRL, K_RUN | K_IED);
        rd(A_CTRL, v);
        chk("R5 done on enable", 32'(v[16]), 32'd1);
        chk("R7 irq from done", 32'(irq), 32'd1);
        wr(A_CTRL, K_IED);
        rd(A_CTRL, v);
        chk("R5 done clears with run", 32'(v[16]), 32'd0);
        chk("R7 irq falls", 32'(irq), 32'd0);

        // All four modes, loopback
        wr(A_DIV, 32'd2);
        for (int m = 0; m < 4; m++) begin
            logic [31:0] mb;
            mb = (m[0] ? K_CPHA : 32'h0) | (m[1] ? K_CPOL : 32'h0);
            wr(A_CTRL, mb | K_FLT | K_FLR);
            chk("R3 sclk rest level", 32'(sclk), 32'(m[1]));
            for (int k = 0; k < 5; k++) wr(A_DATA, 32'(pat(m, k)));
            wr(A_CTRL, mb | K_RUN);
            wait_done("R5 mode transfer completes");
            for (int k = 0; k < 5; k++) begin
                rd(A_DATA, v);
                chk("R3 loopback byte", v, 32'(pat(m, k)));
            end
            chk("R3 sclk back at rest", 32'(sclk), 32'(m[1]));
        end

        // Bit order on the wire, divider 8
        wr(A_DIV, 32'd8);
        wr(A_CTRL, K_FLT | K_FLR);
        wr(A_DATA, 32'hB2);
        cap_en = 1'b1;
        wr(A_CTRL, K_RUN);
        @(negedge clk);
        while (sclk == 1'b0) @(negedge clk);
        half = 0;
        while (sclk == 1'b1) begin @(negedge clk); half++; end
        chk("R4 divider 8 period", 32'(2 * half), 32'd8);
        wait_done("R5 div 8 completes");
        cap_en = 1'b0;
        chk("R2 msb first on mosi", 32'(cap), 32'hB2);
        rd(A_DATA, v); chk("R2 received byte", v, 32'hB2);

        // Divider 2
        wr(A_DIV, 32'd2);
        wr(A_CTRL, K_FLT | K_FLR);
        wr(A_DATA, 32'h3C);
        wr(A_CTRL, K_RUN);
        @(negedge clk);
        while (sclk == 1'b0) @(negedge clk);
        half = 0;
        while (sclk == 1'b1) begin @(negedge clk); half++; end
        chk("R4 divider 2 period", 32'(2 * half), 32'd2);
        wait_done("R5 div 2 completes");
        rd(A_DATA, v); chk("R2 received byte div 2", v, 32'h3C);

        // Watermark, full, stall
        wr(A_CTRL, K_FLT | K_FLR | K_IER);
        for (int k = 0; k < 11; k++) wr(A_DATA, 32'(pat(7, k)));
        wr(A_CTRL, K_RUN | K_IER);
        wait_done("R5 eleven bytes");
        rd(A_CTRL, v);
        chk("R6 mark clear at 11", 32'(v[19]), 32'd0);
        chk("R7 irq low below mark", 32'(irq), 32'd0);
        wr(A_DATA, 32'(pat(7, 11)));
        wait_done("R5 twelfth byte");
        rd(A_CTRL, v);
        chk("R6 mark set at 12", 32'(v[19]), 32'd1);
        chk("R6 not full at 12", 32'(v[20]), 32'd0);
        chk("R7 irq from rx mark", 32'(irq), 32'd1);
        for (int k = 12; k < 16; k++) wr(A_DATA, 32'(pat(7, k)));
        wait_done("R5 sixteen bytes");
        rd(A_CTRL, v);
        chk("R6 full at 16", 32'(v[20]), 32'd1);
        wr(A_DATA, 32'(pat(7, 16)));
        repeat (60) @(negedge clk);
        rd(A_CTRL, v);
        chk("R11 stalled, not done", 32'(v[16]), 32'd0);
        chk("R11 rx still full", 32'(v[20]), 32'd1);
        rd(A_DATA, v); chk("R11 first byte kept", v, 32'(pat(7, 0)));
        wait_done("R11 resumes after read");
        for (int k = 1; k < 17; k++) begin
            rd(A_DATA, v);
            chk("R11 order kept across stall", v, 32'(pat(7, k)));
        end
        rd(A_CTRL, v);
        chk("R6 queue drained", 32'(v[17]), 32'd0);
        chk("R7 irq falls after drain", 32'(irq), 32'd0);

        // Dropped write when the transmit queue is full
        wr(A_CTRL, K_FLT | K_FLR);
        for (int k = 0; k < 17; k++) wr(A_DATA, 32'(pat(9, k)));
        rd(A_CTRL, v);
        chk("R9 no room when full", 32'(v[18]), 32'd0);
        wr(A_CTRL, K_RUN);
        wait_done("R9 drain");
        for (int k = 0; k < 16; k++) begin
            rd(A_DATA, v);
            chk("R9 first sixteen", v, 32'(pat(9, k)));
        end
        rd(A_CTRL, v);
        chk("R9 seventeenth dropped", 32'(v[17]), 32'd0);
        rd(A_DATA, v); chk("R10 empty read zero", v, 32'h0);
        rd(A_CTRL, v); chk("R10 still empty", 32'(v[17]), 32'd0);
        wr(A_DATA, 32'h5A);
        wait_done("R10 next transfer");
        rd(A_DATA, v); chk("R10 pointers intact", v, 32'h5A);

        // Flush strobes
        wr(A_CTRL, 32'h0);
        for (int k = 0; k < 3; k++) wr(A_DATA, 32'(pat(3, k)));
        wr(A_CTRL, K_FLT);
        rd(A_CTRL, v);
        chk("R12 flush bits read zero", 32'(v[5:4]), 32'd0);
        wr(A_CTRL, K_RUN);
        rd(A_CTRL, v);
        chk("R12 tx flushed, done at once", 32'(v[16]), 32'd1);
        wr(A_DATA, 32'h11); wr(A_DATA, 32'h22);
        wait_done("R12 refill");
        wr(A_CTRL, K_RUN | K_FLR);
        rd(A_CTRL, v);
        chk("R12 rx flushed", 32'(v[17]), 32'd0);

        // Chip selects
        for (int i = 0; i < 3; i++) begin
            logic [31:0] lp;
            lp = 32'h1 << (21 + i);
            wr(A_CTRL, K_RUN | 32'(i));
            chk("R8 active-low select", 32'(cs_line), 32'(3'b111 & ~(3'b001 << i)));
            wr(A_CTRL, K_RUN | lp | 32'(i));
            chk("R8 active-high select", 32'(cs_line), 32'h7);
            wr(A_CTRL, lp | 32'(i));
            chk("R8 active-high idle", 32'(cs_line), 32'(3'b111 & ~(3'b001 << i)));
        end
        wr(A_CTRL, K_RUN | 32'd3);
        chk("R8 pick 3 selects none", 32'(cs_line), 32'h7);
        wr(A_CTRL, K_RUN | K_POLALL | 32'd1);
        chk("R8 shared polarity", 32'(cs_line), 32'h2);

        // Divider 0: first half period only, then reset
        wr(A_CTRL, 32'h0);
        wr(A_DIV, 32'h0);
        wr(A_DATA, 32'hC3);
        wr(A_CTRL, K_RUN);
        @(negedge clk);
        while (sclk == 1'b0) @(negedge clk);
        half = 0;
        while (sclk == 1'b1) begin @(negedge clk); half++; end
        chk("R4 divider 0 period", 32'(2 * half), 32'd65536);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        rd(A_CTRL, v); chk("R1 ctrl after second reset", v, 32'h0004_0000);

        summary();
        $finish;
    end

endmodule